// File: doc/BRIEF.md
# Per-Stream Fractional Bit Delay Aligner

This block takes several serial TDM input lines and realigns each one against a shared frame pulse. Every stream has its own delay, counted in quarter-bit steps, so that unequal wiring and path lengths in a large switching system can be absorbed. The block also picks the point inside each bit cell at which the line is sampled: the middle of the cell or the three-quarter point. The master clock runs at four times the fastest line rate. Streams are split into groups, and each group runs at 8.192, 4.096 or 2.048 Mbps, chosen by a 2-bit rate code.

Delay values are written into a shadow bank through a simple write port, one stream per write. The shadow values and the group rate codes are copied into the working set only when a frame pulse arrives. Each stream delays its own frame start by its delay, counts bit cells from that point, and presents every recovered bit with a one-cycle strobe and the bit's index within the frame. A stream keeps recovering the tail of the previous frame until its own delayed start for the new frame is reached.

Top module: `tdm_skew_aligner`

## Requirements
- R1: While reset is high, and in the cycle after it, every strobe, every recovered bit, every bit index and every rate error flag is zero.
- R2: A write of `wr_skew_i` holds a 6-bit skew word. Bits [4:0] are the delay in quarter bits (0 to 31, which is 0 to 7 3/4 bits). Bit 5 picks the sample point. One quarter bit lasts 1, 2 or 4 clock ticks at rate code 00, 01 or 10. A frame pulse seen in tick 0 starts the stream's bit 0 at tick D, where D is the quarter count times the quarter length.
- R3: A bit cell lasts four quarters. Successive strobes of a running stream are exactly one cell apart. The bit index is 0 for the first bit after the stream's delayed frame start and rises by one per cell.
- R4: With bit 5 clear, the line is sampled at quarter 2 of the cell (the midpoint). With bit 5 set, it is sampled at quarter 3. The sampled value appears on `bit_o`, together with `bit_vld_o` high for exactly one cycle, after the clock edge of the sample tick.
- R5: Stream s belongs to group s / (streams per group). Group g takes its rate code from `rate_sel_i[2g+1:2g]`: 00 gives 8.192 Mbps, 01 gives 4.096 Mbps, 10 gives 2.048 Mbps.
- R6: Rate code 11 is reserved. A stream in such a group gives no strobes, and its `bit_o` is held at zero from its delayed frame start. The group's `rate_err_o` bit is set at a frame pulse that samples code 11, and stays set until reset.
- R7: A skew write has no effect on the running frame. It takes effect at the next frame pulse. A write made in the same cycle as a frame pulse waits for the pulse after that.
- R8: After a frame pulse, each stream goes on recovering the previous frame's bits, with that frame's delay, rate and sample point, until its own new delayed start. At that tick the new frame wins.
- R9: Before the first frame pulse after reset, no strobe is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, four ticks per bit at the fastest rate |
| rst_i | input | 1 | Synchronous active-high reset |
| fp_i | input | 1 | Frame pulse, one tick wide, marks tick 0 of a frame |
| rate_sel_i | input | 2*NUM_GROUPS | Rate code per group, two bits per group |
| line_i | input | NUM_STREAMS | Serial input lines |
| wr_en_i | input | 1 | Skew write strobe |
| wr_sel_i | input | $clog2(NUM_STREAMS) | Stream addressed by the write |
| wr_skew_i | input | 6 | Skew word: [5] late sample, [4:0] quarter count |
| bit_o | output | NUM_STREAMS | Recovered bit per stream |
| bit_vld_o | output | NUM_STREAMS | One-cycle strobe per recovered bit |
| bit_idx_o | output | NUM_STREAMS*IDX_W | Bit index within the frame, IDX_W bits per stream |
| rate_err_o | output | NUM_GROUPS | Sticky flag: reserved rate code sampled |

## Verification
Two pairs of events can fall in the same tick. In the first, a skew write lands in the frame pulse cycle. The bench queues writes at tick 0 and then checks that the old shadow value still governs the new frame, and that the written value governs only the frame after it. In the second, a stream's new delayed start lands while that stream is still sampling the previous frame's tail. The bench provokes this by switching a stream from the slowest rate with the largest delay to the fastest rate with a small delay. Every tick's strobe, bit and index is then compared against a model that hands each tick either to the old frame or to the new one.

// File: rtl/tdm_skew_pkg.sv
package tdm_skew_pkg;

    localparam int QTR_W     = 5;            // quarter-bit count field
    localparam int DLY_W     = QTR_W + 1;    // plus sample-point select
    localparam int OFF_W     = QTR_W + 2;    // ticks: up to 31 * 4
    localparam int CELL_SH_W = 4;            // widest cell is 16 ticks

    typedef enum logic [1:0] {
        RATE_HI  = 2'b00,
        RATE_MID = 2'b01,
        RATE_LO  = 2'b10,
        RATE_BAD = 2'b11
    } rate_e;

    typedef struct packed {
        logic             late;   // 1: sample at 3/4, 0: at 1/2
        logic [QTR_W-1:0] qtr;    // delay in quarter bits
    } skew_t;

    // log2 of the ticks per quarter bit
    function automatic logic [1:0] tick_shift(rate_e r);
        case (r)
            RATE_MID: return 2'd1;
            RATE_LO:  return 2'd2;
            default:  return 2'd0;
        endcase
    endfunction

    function automatic logic [OFF_W-1:0] skew_ticks(skew_t d, rate_e r);
        return OFF_W'(d.qtr) << tick_shift(r);
    endfunction

    function automatic logic [CELL_SH_W-1:0] sample_tick(logic late, rate_e r);
        logic [CELL_SH_W-1:0] base;
        base = late ? 4'd3 : 4'd2;
        return base << tick_shift(r);
    endfunction

endpackage

// File: rtl/tdm_skew_cfg.sv
module tdm_skew_cfg
    import tdm_skew_pkg::*;
#(
    parameter int NS    = 4,
    parameter int NG    = 2,
    parameter int SEL_W = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             fp_i,
    input  logic             wr_en_i,
    input  logic [SEL_W-1:0] wr_sel_i,
    input  skew_t            wr_skew_i,
    input  rate_e            mode_i [NG],
    output skew_t            shd_o [NS],
    output skew_t            act_o [NS],
    output rate_e            act_rate_o [NG],
    output logic [NG-1:0]    err_o
);

    for (genvar s = 0; s < NS; s++) begin : g_stream
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                shd_o[s] <= '0;
                act_o[s] <= '0;
            end else begin
                if (wr_en_i && wr_sel_i == SEL_W'(s)) shd_o[s] <= wr_skew_i;
                if (fp_i) act_o[s] <= shd_o[s];   // old shadow wins on a tie
            end
        end
    end

    for (genvar g = 0; g < NG; g++) begin : g_group
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                act_rate_o[g] <= RATE_HI;
                err_o[g]      <= 1'b0;
            end else if (fp_i) begin
                act_rate_o[g] <= mode_i[g];
                if (mode_i[g] == RATE_BAD) err_o[g] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/tdm_skew_lane.sv
module tdm_skew_lane
    import tdm_skew_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             fp_i,
    input  skew_t            shd_i,
    input  logic             act_late_i,
    input  rate_e            nxt_rate_i,
    input  rate_e            act_rate_i,
    input  logic             line_i,
    output logic             bit_o,
    output logic             vld_o,
    output logic [IDX_W-1:0] idx_o
);

    localparam int POS_W = IDX_W + CELL_SH_W;

    logic [OFF_W-1:0] wait_q;
    logic             pend_q;
    logic             run_q;
    logic [POS_W-1:0] pos_q;
    logic             late_q;
    rate_e            rate_q;

    logic [OFF_W-1:0] lead;
    logic             start;
    logic             src_late;
    rate_e            src_rate;
    rate_e            use_rate;
    logic             use_late;
    logic             run_now;
    logic [POS_W-1:0] pos_now;
    logic [1:0]       sh;
    logic [POS_W-1:0] cell_mask;
    logic [POS_W-1:0] samp_pos;
    logic [POS_W-1:0] bit_pos;
    logic             hit;
    logic             mute;

    always_comb begin
        lead     = skew_ticks(shd_i, nxt_rate_i);
        start    = fp_i ? (lead == '0) : (pend_q && wait_q == OFF_W'(1));
        src_late = fp_i ? shd_i.late : act_late_i;
        src_rate = fp_i ? nxt_rate_i : act_rate_i;
        use_rate = start ? src_rate : rate_q;
        use_late = start ? src_late : late_q;
        pos_now  = start ? '0 : pos_q;
        run_now  = run_q | start;
        sh       = tick_shift(use_rate);
        cell_mask = (POS_W'(4) << sh) - POS_W'(1);
        samp_pos = POS_W'(sample_tick(use_late, use_rate));
        bit_pos  = pos_now >> ({1'b0, sh} + 3'd2);
        mute     = run_now && (use_rate == RATE_BAD);
        hit      = run_now && !mute && ((pos_now & cell_mask) == samp_pos);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            wait_q <= '0;
            pend_q <= 1'b0;
            run_q  <= 1'b0;
            pos_q  <= '0;
            late_q <= 1'b0;
            rate_q <= RATE_HI;
            bit_o  <= 1'b0;
            vld_o  <= 1'b0;
            idx_o  <= '0;
        end else begin
            if (fp_i) begin
                wait_q <= lead;
                pend_q <= (lead != '0);
            end else if (pend_q) begin
                wait_q <= wait_q - OFF_W'(1);
                if (wait_q == OFF_W'(1)) pend_q <= 1'b0;
            end
            if (start) begin
                rate_q <= src_rate;
                late_q <= src_late;
                run_q  <= 1'b1;
            end
            pos_q <= run_now ? pos_now + POS_W'(1) : '0;
            vld_o <= hit;
            if (hit) begin
                bit_o <= line_i;
                idx_o <= bit_pos[IDX_W-1:0];
            end else if (mute) begin
                bit_o <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tdm_skew_aligner.sv
module tdm_skew_aligner
    import tdm_skew_pkg::*;
#(
    parameter int NUM_STREAMS = 4,
    parameter int NUM_GROUPS  = 2,
    parameter int IDX_W       = 10
) (
    input  logic                              clk_i,
    input  logic                              rst_i,
    input  logic                              fp_i,
    input  logic [2*NUM_GROUPS-1:0]           rate_sel_i,
    input  logic [NUM_STREAMS-1:0]            line_i,
    input  logic                              wr_en_i,
    input  logic [$clog2(NUM_STREAMS)-1:0]    wr_sel_i,
    input  logic [DLY_W-1:0]                  wr_skew_i,
    output logic [NUM_STREAMS-1:0]            bit_o,
    output logic [NUM_STREAMS-1:0]            bit_vld_o,
    output logic [NUM_STREAMS*IDX_W-1:0]      bit_idx_o,
    output logic [NUM_GROUPS-1:0]             rate_err_o
);

    localparam int SEL_W   = $clog2(NUM_STREAMS);
    localparam int PER_GRP = NUM_STREAMS / NUM_GROUPS;

    rate_e grp_rate [NUM_GROUPS];
    rate_e act_rate [NUM_GROUPS];
    skew_t shd_skew [NUM_STREAMS];
    skew_t act_skew [NUM_STREAMS];
    logic [NUM_STREAMS*DLY_W-1:0] act_skew_flat;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_rate
        assign grp_rate[g] = rate_e'(rate_sel_i[2*g +: 2]);
    end

    tdm_skew_cfg #(
        .NS    (NUM_STREAMS),
        .NG    (NUM_GROUPS),
        .SEL_W (SEL_W)
    ) u_cfg (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .fp_i       (fp_i),
        .wr_en_i    (wr_en_i),
        .wr_sel_i   (wr_sel_i),
        .wr_skew_i  (skew_t'(wr_skew_i)),
        .mode_i     (grp_rate),
        .shd_o      (shd_skew),
        .act_o      (act_skew),
        .act_rate_o (act_rate),
        .err_o      (rate_err_o)
    );

    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_lane
        assign act_skew_flat[s*DLY_W +: DLY_W] = act_skew[s];

        tdm_skew_lane #(
            .IDX_W (IDX_W)
        ) u_lane (
            .clk_i      (clk_i),
            .rst_i      (rst_i),
            .fp_i       (fp_i),
            .shd_i      (shd_skew[s]),
            .act_late_i (act_skew[s].late),
            .nxt_rate_i (grp_rate[s / PER_GRP]),
            .act_rate_i (act_rate[s / PER_GRP]),
            .line_i     (line_i[s]),
            .bit_o      (bit_o[s]),
            .vld_o      (bit_vld_o[s]),
            .idx_o      (bit_idx_o[s*IDX_W +: IDX_W])
        );
    end

endmodule

// File: rtl/tdm_skew_chk.sv
module tdm_skew_chk #(
    parameter int NS    = 4,
    parameter int NG    = 2,
    parameter int DLY_W = 6
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              fp_i,
    input logic [NS-1:0]     vld_i,
    input logic [NG-1:0]     err_i,
    input logic [NS*DLY_W-1:0] act_flat_i
);

    logic seen_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) seen_q <= 1'b0;
        else       seen_q <= seen_q | fp_i;
    end

    a_r1_reset_clears: assert property (@(posedge clk_i)
        rst_i |=> (vld_i == '0 && err_i == '0));

    a_r3_single_tick_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
        (vld_i != '0) |=> ((vld_i & $past(vld_i)) == '0));

    a_r6_err_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
        (err_i != '0) |=> ((err_i & $past(err_i)) == $past(err_i)));

    a_r7_skew_frozen_midframe: assert property (@(posedge clk_i) disable iff (rst_i)
        !fp_i |=> $stable(act_flat_i));

    a_r9_quiet_before_frame: assert property (@(posedge clk_i) disable iff (rst_i)
        !seen_q |-> (vld_i == '0));

endmodule

bind tdm_skew_aligner tdm_skew_chk #(
    .NS    (NUM_STREAMS),
    .NG    (NUM_GROUPS),
    .DLY_W (tdm_skew_pkg::DLY_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .fp_i       (fp_i),
    .vld_i      (bit_vld_o),
    .err_i      (rate_err_o),
    .act_flat_i (act_skew_flat)
);

// File: tb/tdm_skew_aligner_bench.sv
module tdm_skew_aligner_bench;

    localparam int NS = 4;
    localparam int NG = 2;
    localparam int IW = 10;
    localparam int FLEN = 160;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fp = 1'b0;
    logic [3:0]    rate_sel = '0;
    logic [NS-1:0] line = '0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = '0;
    logic [5:0]    wr_skew = '0;
    logic [NS-1:0] bit_o;
    logic [NS-1:0] vld_o;
    logic [NS*IW-1:0] idx_o;
    logic [NG-1:0] err_o;

    always #4 clk = ~clk;

    tdm_skew_aligner #(.NUM_STREAMS(NS), .NUM_GROUPS(NG), .IDX_W(IW)) u_tdm_skew_aligner (
        .clk_i(clk), .rst_i(rst), .fp_i(fp), .rate_sel_i(rate_sel), .line_i(line),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_skew_i(wr_skew),
        .bit_o(bit_o), .bit_vld_o(vld_o), .bit_idx_o(idx_o), .rate_err_o(err_o)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    // reference model state
    logic [5:0] shd_m [NS];
    logic [5:0] cur_m [NS];
    logic [5:0] prv_m [NS];
    int         cur_r [NS];
    int         prv_r [NS];
    int         mode_m [NG];
    bit         cur_ok = 0, prv_ok = 0;
    int         prv_flen = 0, last_flen = 0, frm = 0;
    int         pw_n = 0;
    int         pw_tick [8];
    int         pw_sel [8];
    logic [5:0] pw_val [8];

    task automatic check(string req, int s, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s stream %0d t=%0t actual=%0d expected=%0d", req, s, $time, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    function automatic int qlen(int r);
        return (r == 1) ? 2 : (r == 2) ? 4 : 1;
    endfunction

    function automatic logic pat(int s, int k, int f);
        logic [31:0] v;
        v = 32'(s * 7 + k * 13 + f * 29);
        v = v ^ (v >> 3) ^ 32'(k * k);
        return ^v;
    endfunction

    // Line value for tick tt, plus the expected strobe / bit / index.
    function automatic void model(input int s, input int tt, output logic ln,
                                  output logic ev, output logic bz, output logic eb, output int ek);
        logic [5:0] d;
        int r, rel, f, q, bl, sq, ph, offc;
        bit have;
        have = 0; ln = 0; ev = 0; bz = 0; eb = 0; ek = 0;
        d = '0; r = 0; rel = 0; f = 0;
        offc = int'(cur_m[s][4:0]) * qlen(cur_r[s]);
        if (cur_ok && tt >= offc) begin
            d = cur_m[s]; r = cur_r[s]; rel = tt - offc; f = frm; have = 1;
        end else if (prv_ok) begin
            d = prv_m[s]; r = prv_r[s];
            rel = tt + prv_flen - int'(prv_m[s][4:0]) * qlen(prv_r[s]);
            f = frm - 1; have = 1;
        end
        if (!have) return;
        if (r == 3) begin bz = 1; return; end
        q = qlen(r); bl = 4 * q; sq = d[5] ? 3 : 2;
        ek = rel / bl; ph = rel % bl;
        eb = pat(s, ek, f);
        ln = eb ^ ((ph / q) != sq);   // only the programmed quarter carries the true bit
        ev = (ph == sq * q);
    endfunction

    task automatic queue_write(int tick, int sel, logic [5:0] val);
        pw_tick[pw_n] = tick; pw_sel[pw_n] = sel; pw_val[pw_n] = val; pw_n++;
    endtask

    task automatic run_frame(string req, int flen);
        logic ln, bz;
        logic e_v [NS];
        logic e_z [NS];
        logic e_b [NS];
        int   e_k [NS];
        for (int tt = 0; tt < flen; tt++) begin
            if (tt == 0) begin
                for (int s = 0; s < NS; s++) begin
                    prv_m[s] = cur_m[s]; prv_r[s] = cur_r[s];
                    cur_m[s] = shd_m[s]; cur_r[s] = mode_m[s / 2];
                end
                prv_ok = cur_ok; prv_flen = last_flen; cur_ok = 1; frm++;
            end
            fp = (tt == 0);
            rate_sel = {2'(mode_m[1]), 2'(mode_m[0])};
            wr_en = 1'b0;
            for (int i = 0; i < pw_n; i++) begin
                if (pw_tick[i] == tt) begin
                    wr_en = 1'b1; wr_sel = 2'(pw_sel[i]); wr_skew = pw_val[i];
                    shd_m[pw_sel[i]] = pw_val[i];
                end
            end
            for (int s = 0; s < NS; s++) begin
                model(s, tt, ln, e_v[s], bz, e_b[s], e_k[s]);
                e_z[s] = bz;
                line[s] = ln;
            end
            @(negedge clk);
            for (int s = 0; s < NS; s++) begin
                check(req, s, int'(vld_o[s]), int'(e_v[s]));
                if (e_v[s]) begin
                    check(req, s, int'(bit_o[s]), int'(e_b[s]));
                    check(req, s, int'(idx_o[s*IW +: IW]), e_k[s]);
                end
                if (e_z[s]) check(req, s, int'(bit_o[s]), 0);
            end
        end
        fp = 1'b0; wr_en = 1'b0;
        last_flen = flen; pw_n = 0;
    endtask

    // R1 and R9: reset state, then silence before any frame pulse
    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", 0, int'(vld_o), 0);
        check("R1", 0, int'(bit_o), 0);
        check("R1", 0, int'(idx_o), 0);
        check("R1", 0, int'(err_o), 0);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) begin
            line = 4'(i * 5);
            @(negedge clk);
            check("R9", 0, int'(vld_o), 0);
        end
    endtask

    // R2..R5: every delay value and both sample points at every rate
    task automatic t_sweep();
        for (int r = 0; r < 3; r++) begin
            mode_m[0] = r; mode_m[1] = r;
            for (int p = 0; p < 9; p++) begin
                for (int s = 0; s < NS; s++)
                    queue_write(1 + s, s, {1'((p + s) & 1), 5'((p % 8) * 4 + s)});
                run_frame("R2,R3,R4,R5", FLEN);
            end
        end
    endtask

    // R5: groups run at different rates in the same frame
    task automatic t_groups();
        mode_m[0] = 0; mode_m[1] = 2;
        queue_write(2, 0, 6'h23); queue_write(3, 3, 6'h05);
        run_frame("R5", FLEN);
        mode_m[0] = 1; mode_m[1] = 0;
        run_frame("R5", FLEN);
    endtask

    // R7: mid-frame write and a write in the frame-pulse cycle
    task automatic t_midframe();
        mode_m[0] = 0; mode_m[1] = 0;
        queue_write(0, 2, 6'h3A);
        queue_write(60, 1, 6'h11);
        run_frame("R7", FLEN);
        run_frame("R7", FLEN);
        run_frame("R7", FLEN);
    endtask

    // R8: long slow tail of the old frame overlapping a fast new frame
    task automatic t_tail();
        mode_m[0] = 2; mode_m[1] = 2;
        for (int s = 0; s < NS; s++) queue_write(1 + s, s, 6'(31 - s));
        run_frame("R8", FLEN);
        run_frame("R8", FLEN);
        mode_m[0] = 0; mode_m[1] = 0;
        for (int s = 0; s < NS; s++) queue_write(1 + s, s, 6'(s * 9));
        run_frame("R8", FLEN);
        run_frame("R8", FLEN);
    endtask

    // R6: reserved code mutes its group and latches a sticky flag
    task automatic t_reserved();
        mode_m[0] = 0; mode_m[1] = 3;
        run_frame("R6", FLEN);
        check("R6", 0, int'(err_o), 2);
        run_frame("R6", FLEN);
        mode_m[1] = 1;
        run_frame("R6", FLEN);
        check("R6", 0, int'(err_o), 2);
        run_frame("R6", FLEN);
    endtask

    initial begin
        for (int s = 0; s < NS; s++) begin
            shd_m[s] = '0; cur_m[s] = '0; prv_m[s] = '0; cur_r[s] = 0; prv_r[s] = 0;
        end
        mode_m[0] = 0; mode_m[1] = 0;
        @(negedge clk);
        t_reset();
        t_sweep();
        t_groups();
        t_midframe();
        t_tail();
        t_reserved();
        finish_run();
    end

endmodule